// File: doc/BRIEF.md
# Hysteretic Tone Band Selector

This block looks at a tone that has already been squared into a single digital bit and clocked into the system clock domain. From it, the block decides whether the tone belongs to the low call-progress band or the high band. It counts the rising edges of the tone inside a fixed window of system clocks. When each window closes, it sorts the count into one of three classes: low, high, or neither.

The band decision has memory. A count in the band already selected changes nothing. A count in the opposite band flips the band and emits a one-cycle pulse, which a downstream frequency counter uses to abandon the measurement it has in progress. A count that fits neither band leaves the band alone and raises an out-of-range flag. A level detector drives the enable input. While enable is low, the window restarts and the band is frozen.

With a 3.579545 MHz clock, the default window is 35080 clocks, which is about 9.8 ms. In that window a 300–660 Hz tone gives 2 to 7 edges and a 900–2150 Hz tone gives 8 to 22 edges. Tones between the two bands give counts that fall outside both classes.

Top module: `toneBandSelector`

## Requirements
- R1: After reset, `bandHi` is 0 (low band), `bandChange` is 0 and `outOfRange` is 0.
- R2: The band is re-decided once per `WIN_CLKS` consecutive enabled clocks. Outputs change only on the clock edge that closes a window. The first decision lands on the `WIN_CLKS`-th clock edge after reset is released.
- R3: A window holding LO_MIN..LO_MAX rising edges (default 2 to 7) selects the low band (`bandHi` = 0).
- R4: A window holding HI_MIN..HI_MAX rising edges (default 8 to 22) selects the high band (`bandHi` = 1).
- R5: A window whose count falls in the band already selected keeps that band and produces no pulse.
- R6: A window whose count fits neither class (default 0, 1, or 23 and up) leaves `bandHi` unchanged and sets `outOfRange` to 1. A window with an in-class count clears `outOfRange`.
- R7: `bandChange` is high for exactly one clock, starting at the window close where `bandHi` flips, and at no other time.
- R8: While `enable` is 0, the window timer and the edge count are held at zero, `bandHi` is held, and `outOfRange` and `bandChange` are 0. A full new window starts with the first enabled clock.
- R9: The edge count saturates instead of wrapping. A window with very many edges (for example 40) therefore reads as out of range and never as a valid band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| toneIn | input | 1 | Squared tone, synchronous to clk |
| enable | input | 1 | Level-detector enable; low freezes the selector |
| bandHi | output | 1 | Selected band: 1 high, 0 low |
| bandChange | output | 1 | One-cycle pulse when the band flips |
| outOfRange | output | 1 | Last window's count fitted neither band |

## Verification
Every cycle, the embedded assertions check the following:
- The window counter stays in range.
- The window counter is cleared after a disabled clock.
- `bandHi` moves only at a window close.
- A change pulse always comes with a real flip of the band, and never lasts two cycles.
- `outOfRange` and `bandChange` are quiet after a disabled clock.
- `outOfRange` rises only at a window close.

Only the directed scenarios can show the following:
- Which edge counts map to which band, at both ends of each class.
- That the band stays put across repeated same-band windows.
- That saturation stops a large count from wrapping into a valid class.
- That edges seen while disabled are discarded, and that a window broken by a disable restarts in full.

// File: rtl/toneBandPkg.sv
package toneBandPkg;

  typedef struct packed {
    logic winEnd;  // last clock of an enabled window
    logic hold;    // selector disabled this clock
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_LO   = 2'd1,
    CLS_HI   = 2'd2
  } edgeClass_t;

  function automatic edgeClass_t classifyCount(
    input int unsigned cnt,
    input int unsigned loMin,
    input int unsigned loMax,
    input int unsigned hiMin,
    input int unsigned hiMax
  );
    if (cnt >= loMin && cnt <= loMax)      return CLS_LO;
    else if (cnt >= hiMin && cnt <= hiMax) return CLS_HI;
    else                                   return CLS_NONE;
  endfunction

endpackage

// File: rtl/toneWindowCtrl.sv
module toneWindowCtrl
  import toneBandPkg::*;
#(
  parameter int unsigned WIN_CLKS = 35080
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  output ctrlStrobe_t strobe
);
  localparam int unsigned WIN_W = $clog2(WIN_CLKS);
  localparam logic [WIN_W-1:0] LAST_CNT = WIN_W'(WIN_CLKS - 1);

  logic [WIN_W-1:0] winCnt;
  logic             lastTick;

  assign lastTick = (winCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (!enable) begin
      winCnt <= '0;
    end else if (lastTick) begin
      winCnt <= '0;
    end else begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.hold   = !enable;
    strobe.winEnd = enable && lastTick;
  end

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= LAST_CNT);

  // R8
  win_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!enable) |-> (winCnt == '0));

endmodule

// File: rtl/toneBandPath.sv
module toneBandPath
  import toneBandPkg::*;
#(
  parameter int unsigned LO_MIN = 2,
  parameter int unsigned LO_MAX = 7,
  parameter int unsigned HI_MIN = 8,
  parameter int unsigned HI_MAX = 22,
  parameter int unsigned CNT_W  = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        toneIn,
  input  ctrlStrobe_t strobe,
  output logic        bandHi,
  output logic        bandChange,
  output logic        outOfRange
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             tonePrev;
  logic             rise;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] total;
  edgeClass_t       winClass;

  assign rise = toneIn && !tonePrev;

  always_comb begin
    if (edgeCnt == CNT_MAX) total = CNT_MAX;
    else                    total = edgeCnt + CNT_W'(rise);
    winClass = classifyCount(int'(total), LO_MIN, LO_MAX, HI_MIN, HI_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) tonePrev <= 1'b0;
    else       tonePrev <= toneIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt    <= '0;
      bandHi     <= 1'b0;
      bandChange <= 1'b0;
      outOfRange <= 1'b0;
    end else if (strobe.hold) begin
      edgeCnt    <= '0;
      bandChange <= 1'b0;
      outOfRange <= 1'b0;
    end else if (strobe.winEnd) begin
      edgeCnt <= '0;
      unique case (winClass)
        CLS_LO: begin
          bandChange <= bandHi;
          bandHi     <= 1'b0;
          outOfRange <= 1'b0;
        end
        CLS_HI: begin
          bandChange <= !bandHi;
          bandHi     <= 1'b1;
          outOfRange <= 1'b0;
        end
        default: begin
          bandChange <= 1'b0;
          outOfRange <= 1'b1;
        end
      endcase
    end else begin
      edgeCnt    <= total;
      bandChange <= 1'b0;
    end
  end

  // R7
  change_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    bandChange |-> (bandHi != $past(bandHi)));

  // R7
  change_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    bandChange |=> !bandChange);

  // R2
  band_cadence_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.winEnd) |-> $stable(bandHi));

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.hold) |-> (!outOfRange && !bandChange));

  // R6
  oor_cadence_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outOfRange) |-> $past(strobe.winEnd));

endmodule

// File: rtl/toneBandSelector.sv
module toneBandSelector
  import toneBandPkg::*;
#(
  parameter int unsigned WIN_CLKS = 35080,
  parameter int unsigned LO_MIN   = 2,
  parameter int unsigned LO_MAX   = 7,
  parameter int unsigned HI_MIN   = 8,
  parameter int unsigned HI_MAX   = 22
) (
  input  logic clk,
  input  logic rstN,
  input  logic toneIn,
  input  logic enable,
  output logic bandHi,
  output logic bandChange,
  output logic outOfRange
);
  localparam int unsigned CNT_W = $clog2(HI_MAX + 2);

  ctrlStrobe_t strobe;

  toneWindowCtrl #(.WIN_CLKS(WIN_CLKS)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .strobe (strobe)
  );

  toneBandPath #(
    .LO_MIN (LO_MIN),
    .LO_MAX (LO_MAX),
    .HI_MIN (HI_MIN),
    .HI_MAX (HI_MAX),
    .CNT_W  (CNT_W)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .toneIn     (toneIn),
    .strobe     (strobe),
    .bandHi     (bandHi),
    .bandChange (bandChange),
    .outOfRange (outOfRange)
  );

endmodule

// File: tb/toneBandSelector_tb_top.sv
module toneBandSelector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 200;

  logic clk = 1'b0;
  logic rstN, toneIn, enable;
  logic bandHi, bandChange, outOfRange;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  toneBandSelector #(.WIN_CLKS(W)) dut_i (
    .clk(clk), .rstN(rstN), .toneIn(toneIn), .enable(enable),
    .bandHi(bandHi), .bandChange(bandChange), .outOfRange(outOfRange)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Drive one full window starting just after a negedge, n pulses of 2 high / 2 low.
  task automatic runWindow(input int n, input logic expHi, input logic expChg,
                           input logic expOor, input string req);
    logic priorHi;
    priorHi = bandHi;
    for (int c = 0; c < W; c++) begin
      toneIn = (c < 4*n) && ((c % 4) < 2);
      @(negedge clk);
      if (c == W-2) begin
        // R2: nothing moves before the window closes
        chk("R2", "band before window end", bandHi, priorHi);
        chk("R2", "pulse before window end", bandChange, 1'b0);
      end
    end
    chk(req, $sformatf("bandHi after %0d edges", n), bandHi, expHi);
    chk(req, $sformatf("bandChange after %0d edges", n), bandChange, expChg);
    chk(req, $sformatf("outOfRange after %0d edges", n), outOfRange, expOor);
  endtask

  task automatic testReset();
    rstN = 1'b0; enable = 1'b1; toneIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "bandHi", bandHi, 1'b0);
    chk("R1", "bandChange", bandChange, 1'b0);
    chk("R1", "outOfRange", outOfRange, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic testSticky();
    runWindow(5, 1'b0, 1'b0, 1'b0, "R3 R5");
    runWindow(12, 1'b1, 1'b1, 1'b0, "R4 R7");
    toneIn = 1'b0;
    runWindow(12, 1'b1, 1'b0, 1'b0, "R5 R7");
  endtask

  task automatic testBoundaries();
    runWindow(0, 1'b1, 1'b0, 1'b1, "R6");
    runWindow(30, 1'b1, 1'b0, 1'b1, "R6");
    runWindow(22, 1'b1, 1'b0, 1'b0, "R4 R6");
    runWindow(7, 1'b0, 1'b1, 1'b0, "R3");
    runWindow(23, 1'b0, 1'b0, 1'b1, "R6");
    runWindow(8, 1'b1, 1'b1, 1'b0, "R4");
    runWindow(2, 1'b0, 1'b1, 1'b0, "R3");
    runWindow(1, 1'b0, 1'b0, 1'b1, "R6");
  endtask

  task automatic testSaturate();
    runWindow(40, 1'b0, 1'b0, 1'b1, "R9");
  endtask

  task automatic testDisable();
    enable = 1'b0;
    for (int c = 0; c < 30; c++) begin
      toneIn = (c < 24) && ((c % 4) < 2);
      @(negedge clk);
    end
    chk("R8", "bandHi held while disabled", bandHi, 1'b0);
    chk("R8", "outOfRange cleared while disabled", outOfRange, 1'b0);
    chk("R8", "no pulse while disabled", bandChange, 1'b0);
    enable = 1'b1;
    // disabled edges must not add to this window (3 + 6 would read high)
    runWindow(3, 1'b0, 1'b0, 1'b0, "R8");
    // break a window part way; the next window must run a full length
    for (int c = 0; c < 100; c++) begin
      toneIn = (c < 12) && ((c % 4) < 2);
      @(negedge clk);
    end
    enable = 1'b0;
    repeat (5) @(negedge clk);
    enable = 1'b1;
    runWindow(12, 1'b1, 1'b1, 1'b0, "R8 R2");
  endtask

  initial begin
    testReset();
    testSticky();
    testBoundaries();
    testSaturate();
    testDisable();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule